// File: doc/BRIEF.md
# Quarter-Wave Sine Oscillator

This block is a numerically controlled sine source. A wide phase register adds a frequency word on every enabled clock and wraps modulo 2^ACC_W, so the output frequency is `tune_word * f_clk / 2^ACC_W`. The highest usable fundamental is half the clock rate. The phase register is never cleared when the word changes, so a new word acts on the next addition without a phase jump. Every carry out of the top bit gives a one-clock `wrap_o` pulse. Downstream logic can use that pulse as a cycle marker.

Only the upper `IDX_W+2` phase bits address the waveform. The lower bits are truncated. The top two of those bits name a quadrant, which is held as an enumerated state. The sequence for small words is Q_RISE (00) → Q_FALL (01) → Q_SINK (10) → Q_RETURN (11) → Q_RISE, and each step happens when the carry crosses that bit pair. Q_RISE reads the quarter table forward. Q_FALL reads it with the index bit-inverted. Q_SINK and Q_RETURN repeat those two readings with the sign negated. The table is built at elaboration and holds only one quarter cycle of magnitudes. The result is a two's-complement sample on `sample_o`, two clocks after the phase it came from.

Top module: `qsine_nco`

## Requirements
- R1: While `rst` is high at a clock edge, the phase register is cleared and `sample_o` and `wrap_o` read 0. On the first edge after reset is released, `sample_o` is still 0.
- R2: On each edge with `en` high and `rst` low, the phase becomes `(phase + tune_word) mod 2^ACC_W`.
- R3: `wrap_o` is high for exactly the one cycle that follows an enabled addition that carried out of bit ACC_W-1. It is low in every other cycle.
- R4: With `en` low, the phase holds, `wrap_o` stays 0, and `sample_o` settles to a constant after two clocks.
- R5: A change of `tune_word` never resets the phase. Accumulation continues from the current value.
- R6: Phase bits below ACC_W-IDX_W-2 have no effect on `sample_o`.
- R7: Quadrant q = phase[ACC_W-1:ACC_W-2] and index k = phase[ACC_W-3:ACC_W-IDX_W-2]. When q[0]=1, the table address is ~k. When q[1]=1, the sample is the negated magnitude.
- R8: Table entry a = round((2^(AMP_W-1)-1) · sin(π(2a+1)/(4·2^IDX_W))). With the defaults, values run from 2 to 511, so `sample_o` is never 0 and never -512 once it is valid.
- R9: `sample_o` in a cycle reflects the phase register value of two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Accumulate enable |
| tune_word | input | ACC_W | Phase increment per clock |
| sample_o | output | AMP_W | Signed amplitude sample |
| wrap_o | output | 1 | One-cycle phase overflow pulse |

## Verification
The bench builds the block with its default parameters: a 28-bit phase register, an 8-bit quarter index and 10-bit samples. With a word of 2^18 the bench steps the phase one table point per clock, so it can walk all 1024 phase points and every quadrant seam. Words near 2^27 and full-scale words bring overflow every clock or every other clock into reach. Words below 2^18 show the truncated bits having no effect.

// File: rtl/qsine_pkg.sv
package qsine_pkg;

    typedef enum logic [1:0] {
        Q_RISE   = 2'b00,
        Q_FALL   = 2'b01,
        Q_SINK   = 2'b10,
        Q_RETURN = 2'b11
    } quad_t;

    // Magnitude of quarter-table entry k, sampled at the middle of each step.
    function automatic int quarter_mag(input int k, input int depth, input int full);
        real ang;
        ang = 3.14159265358979 * real'(2 * k + 1) / real'(4 * depth);
        return $rtoi($sin(ang) * real'(full) + 0.5);
    endfunction

endpackage

// File: rtl/qsine_phase_acc.sv
module qsine_phase_acc #(
    parameter int ACC_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase_o,
    output logic             carry_o
);

    logic [ACC_W:0] sum;

    always_comb begin
        sum = {1'b0, phase_o} + {1'b0, step};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= '0;
            carry_o <= 1'b0;
        end else if (en) begin
            phase_o <= sum[ACC_W-1:0];
            carry_o <= sum[ACC_W];
        end else begin
            carry_o <= 1'b0;
        end
    end

endmodule

// File: rtl/qsine_quarter_lut.sv
module qsine_quarter_lut
    import qsine_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int MAG_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  quad_t            quad,
    input  logic [IDX_W-1:0] idx,
    output logic [MAG_W-1:0] mag_o,
    output logic             neg_o
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int FULL  = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] rom [DEPTH];
    logic [IDX_W-1:0] addr;
    logic             neg;

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        localparam int VAL = quarter_mag(g, DEPTH, FULL);
        assign rom[g] = VAL[MAG_W-1:0];
    end

    always_comb begin
        unique case (quad)
            Q_RISE:   begin addr = idx;  neg = 1'b0; end
            Q_FALL:   begin addr = ~idx; neg = 1'b0; end
            Q_SINK:   begin addr = idx;  neg = 1'b1; end
            Q_RETURN: begin addr = ~idx; neg = 1'b1; end
            default:  begin addr = idx;  neg = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_o <= '0;
            neg_o <= 1'b0;
        end else begin
            mag_o <= rom[addr];
            neg_o <= neg;
        end
    end

endmodule

// File: rtl/qsine_sign_stage.sv
module qsine_sign_stage #(
    parameter int AMP_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AMP_W-2:0] mag,
    input  logic             neg,
    output logic [AMP_W-1:0] sample_o
);

    logic [AMP_W-1:0] ext;

    always_comb begin
        ext = {1'b0, mag};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o <= '0;
        end else begin
            sample_o <= neg ? (~ext + 1'b1) : ext;
        end
    end

endmodule

// File: rtl/qsine_nco.sv
module qsine_nco
    import qsine_pkg::*;
#(
    parameter int ACC_W = 28,
    parameter int IDX_W = 8,
    parameter int AMP_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] tune_word,
    output logic [AMP_W-1:0] sample_o,
    output logic             wrap_o
);

    localparam int PH_W  = IDX_W + 2;
    localparam int MAG_W = AMP_W - 1;

    logic [ACC_W-1:0] acc_q;
    logic [PH_W-1:0]  ph_top;
    quad_t            quad;
    logic [IDX_W-1:0] idx;
    logic [MAG_W-1:0] mag_q;
    logic             neg_q;

    qsine_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .step    (tune_word),
        .phase_o (acc_q),
        .carry_o (wrap_o)
    );

    always_comb begin
        ph_top = acc_q[ACC_W-1 -: PH_W];
        quad   = quad_t'(ph_top[PH_W-1 -: 2]);
        idx    = ph_top[IDX_W-1:0];
    end

    qsine_quarter_lut #(.IDX_W(IDX_W), .MAG_W(MAG_W)) u_lut (
        .clk   (clk),
        .rst   (rst),
        .quad  (quad),
        .idx   (idx),
        .mag_o (mag_q),
        .neg_o (neg_q)
    );

    qsine_sign_stage #(.AMP_W(AMP_W)) u_sign (
        .clk      (clk),
        .rst      (rst),
        .mag      (mag_q),
        .neg      (neg_q),
        .sample_o (sample_o)
    );

endmodule

// File: rtl/qsine_nco_chk.sv
module qsine_nco_chk #(
    parameter int ACC_W = 28,
    parameter int AMP_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             wrap_o,
    input logic [AMP_W-1:0] sample_o,
    input logic [ACC_W-1:0] acc_phase
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    // R3: a pulse only follows an enabled edge
    p_wrap_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> $past(en));

    // R3: pulse present exactly when the phase fell back
    p_wrap_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (en && age != 2'd0) |=> (wrap_o == (acc_phase < $past(acc_phase))));

    // R4: disabled phase holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!en && age != 2'd0) |=> $stable(acc_phase));

    // R7: sign follows the top phase bit two edges back
    p_sign_r7: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (sample_o[AMP_W-1] == $past(acc_phase[ACC_W-1], 2)));

    // R8: valid samples are never zero nor the most negative code
    p_range_r8: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (sample_o != '0 && sample_o != {1'b1, {(AMP_W-1){1'b0}}}));

endmodule

bind qsine_nco qsine_nco_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .wrap_o    (wrap_o),
    .sample_o  (sample_o),
    .acc_phase (acc_q)
);

// File: tb/qsine_nco_tb.sv
module qsine_nco_tb;

    localparam int ACC_W = 28;
    localparam int IDX_W = 8;
    localparam int AMP_W = 10;
    localparam real PI = 3.14159265358979;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en  = 1'b0;
    logic [ACC_W-1:0] tune_word = '0;
    logic [AMP_W-1:0] sample_o;
    logic             wrap_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    qsine_nco #(.ACC_W(ACC_W), .IDX_W(IDX_W), .AMP_W(AMP_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tune_word (tune_word),
        .sample_o  (sample_o),
        .wrap_o    (wrap_o)
    );

    always #4 clk = ~clk;

    // Reference model built from the requirements
    logic [ACC_W-1:0] m_ph, m_h1, m_h2;
    logic             m_v1, m_v2, m_wrap;

    always @(posedge clk) begin
        if (rst) begin
            m_ph <= '0; m_v1 <= 1'b0; m_v2 <= 1'b0; m_wrap <= 1'b0;
            m_h1 <= '0; m_h2 <= '0;
        end else begin
            if (en) begin
                m_ph   <= m_ph + tune_word;
                m_wrap <= ({1'b0, m_ph} + {1'b0, tune_word}) >= (29'd1 << ACC_W);
            end else begin
                m_wrap <= 1'b0;
            end
            m_h1 <= m_ph; m_v1 <= 1'b1;
            m_h2 <= m_h1; m_v2 <= m_v1;
        end
    end

    function automatic logic [AMP_W-1:0] exp_sample(input logic [ACC_W-1:0] ph);
        logic [1:0] q;
        logic [IDX_W-1:0] k;
        int mag;
        q = ph[ACC_W-1 -: 2];
        k = ph[ACC_W-3 -: IDX_W];
        if (q[0]) k = ~k;
        mag = $rtoi($sin(PI * real'(2 * int'(k) + 1) / real'(4 << IDX_W)) * 511.0 + 0.5);
        if (q[1]) mag = -mag;
        return mag[AMP_W-1:0];
    endfunction

    function automatic logic [AMP_W-1:0] model_sample();
        return m_v2 ? exp_sample(m_h2) : '0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [ACC_W-1:0] w);
        @(negedge clk);
        rst = 1'b1; en = 1'b1; tune_word = w;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // compare one cycle against the model
    task automatic cycle_cmp(input string req);
        @(negedge clk);
        check(req, int'($signed(sample_o)), int'($signed(model_sample())));
        check({req, " wrap"}, int'(wrap_o), int'(m_wrap));
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        rst = 1'b1; en = 1'b1; tune_word = 28'h4000000;
        @(negedge clk);
        check("R1 sample in reset", int'(sample_o), 0);
        check("R1 wrap in reset", int'(wrap_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 first sample after release", int'(sample_o), 0);
        @(negedge clk);
        check("R9 phase 0 after two edges", int'($signed(sample_o)), 2);
    endtask

    task automatic t_quadrants_r7();
        // word = quarter turn: phases 0, q1 start, q2 start, q3 start
        do_reset(28'h4000000);
        @(negedge clk); @(negedge clk);
        check("R7 Q_RISE k=0", int'($signed(sample_o)), 2);
        @(negedge clk);
        check("R7 Q_FALL mirrored", int'($signed(sample_o)), 511);
        @(negedge clk);
        check("R7 Q_SINK negated", int'($signed(sample_o)), -2);
        @(negedge clk);
        check("R7 Q_RETURN negated mirror", int'($signed(sample_o)), -511);
        @(negedge clk);
        check("R7 back to Q_RISE", int'($signed(sample_o)), 2);
    endtask

    task automatic t_sweep_r8();
        int lo = 1000, hi = -1000;
        do_reset(28'h0040000);
        for (int i = 0; i < 1030; i++) begin
            cycle_cmp("R8 sweep");
            if (i > 1) begin
                if (int'($signed(sample_o)) < lo) lo = int'($signed(sample_o));
                if (int'($signed(sample_o)) > hi) hi = int'($signed(sample_o));
            end
        end
        check("R8 peak", hi, 511);
        check("R8 trough", lo, -511);
    endtask

    task automatic t_wrap_r3();
        int wraps = 0;
        do_reset(28'h7FFFFFF);
        for (int i = 0; i < 100; i++) begin
            cycle_cmp("R3 near-Nyquist");
            wraps += int'(wrap_o);
        end
        check("R3 wrap count over 100 clocks", wraps, 49);
        @(negedge clk);
        tune_word = 28'hFFFFFFF;
        for (int i = 0; i < 10; i++) cycle_cmp("R3 full-scale word");
    endtask

    task automatic t_accumulate_r2();
        do_reset(28'h5555555);
        for (int i = 0; i < 200; i++) cycle_cmp("R2 accumulate");
    endtask

    task automatic t_enable_r4();
        logic [AMP_W-1:0] held;
        do_reset(28'h1234567);
        for (int i = 0; i < 20; i++) cycle_cmp("R4 before hold");
        en = 1'b0;
        @(negedge clk); @(negedge clk);
        held = sample_o;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R4 sample held", int'(sample_o), int'(held));
            check("R4 no wrap", int'(wrap_o), 0);
        end
        en = 1'b1;
        for (int i = 0; i < 40; i++) cycle_cmp("R4 resume");
    endtask

    task automatic t_retune_r5();
        do_reset(28'h0300000);
        for (int i = 0; i < 30; i++) cycle_cmp("R5 first word");
        tune_word = 28'h2A00001;
        for (int i = 0; i < 30; i++) cycle_cmp("R5 second word");
        tune_word = 28'h0000010;
        for (int i = 0; i < 30; i++) cycle_cmp("R5 third word");
    endtask

    task automatic t_truncate_r6();
        do_reset(28'h0000100);
        @(negedge clk);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            check("R6 low bits ignored", int'($signed(sample_o)), 2);
        end
    endtask

    initial begin
        t_reset_r1();
        t_quadrants_r7();
        t_sweep_r8();
        t_wrap_r3();
        t_accumulate_r2();
        t_enable_r4();
        t_retune_r5();
        t_truncate_r6();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule